// File: doc/BRIEF.md
# SMBus Descriptor Ring Fetch Controller

This block sits between software and an SMBus transaction engine. Software fills 16-byte transaction descriptors into a circular ring in memory and then moves a head index forward. The controller keeps its own tail index and walks it toward the head. For each descriptor it reads the fields it needs over a simple request/acknowledge memory port and hands them to the engine. When the engine reports a result, the controller writes the result word back into the descriptor and moves the tail on.

Completion is reported through two sticky status flags and one interrupt line. A descriptor can ask for a "done" flag on completion. Any descriptor that ends without its success bit raises an "error" flag, which reaches the interrupt line only when enabled. A descriptor can also ask the controller to halt when it fails. The ring sits at a fixed base address. Its length is programmed as the number of entries minus one.

Top module: `smb_desc_ring`

## Requirements
- R1: After reset the control, status and ring-size registers read 0, `irq` is low and no memory request is made.
- R2: Register word 0 (control) holds run in bit 0, error-interrupt enable in bit 4 and the head index in bits 23:16. Word 1 (status) holds busy in bit 0, the error flag in bit 4, the done flag in bit 5 and the tail index in bits 23:16. Word 2 holds the last ring index (entries minus one) in bits 7:0, and its upper bits read 0.
- R3: No descriptor is fetched while run is 0 or while tail equals head. When run is 1 and tail differs from head, fetching starts.
- R4: The descriptor at index i lives at byte address BASE_ADDR + 16·i, little-endian. The controller reads word 0 (byte 0 target address with R/W, byte 1 write length or command, byte 2 read length, byte 3 control), word 2 (data pointer bits 31:0) and word 3 (data pointer bits 63:32). It presents these to the engine unchanged.
- R5: When the engine reports done, word 1 of the same descriptor is written with status in byte 4, retry in byte 5, received count in byte 6 and transmitted count in byte 7.
- R6: The tail advances by one when the write-back is acknowledged. It wraps to 0 after it equals the last ring index, and it changes at no other time.
- R7: A completed descriptor whose control bit 6 is set sets the done flag, and the done flag drives `irq` high.
- R8: A completed descriptor whose status bit 0 is clear sets the error flag. The error flag drives `irq` only while the enable bit is 1.
- R9: When a failing descriptor has control bit 7 set, run is cleared at its write-back and no further descriptor is fetched, even though tail differs from head.
- R10: Writing 1 to status bit 4 or 5 clears that flag. Writing 0 leaves it unchanged, and the busy and tail fields cannot be written.
- R11: A memory request and its address are held until acknowledged. The engine hand-off and its fields are held until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access completed |
| eng_valid | output | 1 | Descriptor offered to the engine |
| eng_ready | input | 1 | Engine accepts the descriptor |
| eng_tgt | output | 8 | Target address with R/W bit |
| eng_wlen | output | 8 | Write length or command |
| eng_rlen | output | 8 | Read length |
| eng_ctrl | output | 8 | Descriptor control byte |
| eng_dptr | output | 64 | Data pointer |
| eng_done | input | 1 | Engine finished the current descriptor |
| eng_status | input | 8 | Result status, bit 0 success |
| eng_retry | input | 8 | Retry count |
| eng_rxcnt | input | 8 | Bytes received |
| eng_txcnt | input | 8 | Bytes transmitted |

## Verification
The assertions assume that the memory raises `mem_ack` only while a request is pending. They also assume that the engine raises `eng_ready` only while `eng_valid` is high and pulses `eng_done` only after it has accepted a descriptor. The bench's memory and engine models are written around these rules, with changing wait states on both sides. Software is assumed to keep the head index within the ring, and every head value the bench programs is at most the last index.

// File: rtl/smb_desc_ring.sv
module smb_desc_ring #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [7:0]        eng_tgt,
  output logic [7:0]        eng_wlen,
  output logic [7:0]        eng_rlen,
  output logic [7:0]        eng_ctrl,
  output logic [63:0]       eng_dptr,
  input  logic              eng_done,
  input  logic [7:0]        eng_status,
  input  logic [7:0]        eng_retry,
  input  logic [7:0]        eng_rxcnt,
  input  logic [7:0]        eng_txcnt
);
  localparam int IW = 8;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD2, S_RD3, S_ISSUE, S_WAIT, S_WB} st_t;
  st_t st;

  logic          run, err_en, fl_done, fl_err;
  logic [IW-1:0] head, tail, last;
  logic [31:0]   w0, wb;
  logic [63:0]   dptr;
  logic [1:0]    wsel;

  wire wr_ctl = reg_we && reg_addr == 2'd0;
  wire wr_sts = reg_we && reg_addr == 2'd1;
  wire wr_siz = reg_we && reg_addr == 2'd2;
  wire wb_fin = st == S_WB && mem_ack;
  wire failed = !wb[0];
  wire halt   = wb_fin && failed && w0[31];
  wire busy   = st != S_IDLE;
  wire unused_wbits = &{1'b0, reg_wdata[31:24], reg_wdata[15:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; run <= 1'b0; err_en <= 1'b0; fl_done <= 1'b0; fl_err <= 1'b0;
      head <= '0; tail <= '0; last <= '0; w0 <= '0; wb <= '0; dptr <= '0;
    end else begin
      if (wr_ctl) begin
        run    <= reg_wdata[0];
        err_en <= reg_wdata[4];
        head   <= reg_wdata[23:16];
      end
      if (halt) run <= 1'b0;
      if (wr_siz) last <= reg_wdata[7:0];
      fl_done <= (fl_done & ~(wr_sts & reg_wdata[5])) | (wb_fin & w0[30]);
      fl_err  <= (fl_err  & ~(wr_sts & reg_wdata[4])) | (wb_fin & failed);
      if (wb_fin) tail <= (tail == last) ? '0 : tail + 1'b1;
      case (st)
        S_IDLE:  if (run && tail != head) st <= S_RD0;
        S_RD0:   if (mem_ack) begin w0 <= mem_rdata; st <= S_RD2; end
        S_RD2:   if (mem_ack) begin dptr[31:0] <= mem_rdata; st <= S_RD3; end
        S_RD3:   if (mem_ack) begin dptr[63:32] <= mem_rdata; st <= S_ISSUE; end
        S_ISSUE: if (eng_ready) st <= S_WAIT;
        S_WAIT:  if (eng_done) begin
                   wb <= {eng_txcnt, eng_rxcnt, eng_retry, eng_status};
                   st <= S_WB;
                 end
        S_WB:    if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_RD2:   wsel = 2'd2;
      S_RD3:   wsel = 2'd3;
      S_WB:    wsel = 2'd1;
      default: wsel = 2'd0;
    endcase
  end

  assign mem_req   = st == S_RD0 || st == S_RD2 || st == S_RD3 || st == S_WB;
  assign mem_we    = st == S_WB;
  assign mem_addr  = BASE_ADDR + ADDR_W'({tail, wsel, 2'b00});
  assign mem_wdata = wb;

  assign eng_valid = st == S_ISSUE;
  assign eng_tgt   = w0[7:0];
  assign eng_wlen  = w0[15:8];
  assign eng_rlen  = w0[23:16];
  assign eng_ctrl  = w0[31:24];
  assign eng_dptr  = dptr;

  assign irq = fl_done | (fl_err & err_en);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {8'h0, head, 11'h0, err_en, 3'h0, run};
      2'd1:    reg_rdata = {8'h0, tail, 10'h0, fl_done, fl_err, 3'h0, busy};
      2'd2:    reg_rdata = {24'h0, last};
      default: reg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/smb_desc_ring_chk.sv
module smb_desc_ring_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              eng_valid,
  input logic              eng_ready,
  input logic [7:0]        eng_ctrl,
  input logic [63:0]       eng_dptr,
  input logic [7:0]        tail,
  input logic [7:0]        last,
  input logic              run,
  input logic              irq,
  input logic              reg_we,
  input logic [1:0]        reg_addr
);
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r11_eng_hold: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_ready |=> eng_valid && $stable(eng_dptr) && $stable(eng_ctrl));

  a_r6_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_we && mem_ack) |=> $stable(tail));

  a_r6_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=>
      (($past(tail) != $past(last)) && tail == $past(tail) + 8'd1) ||
      (($past(tail) == $past(last)) && tail == 8'd0));

  a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack && eng_ctrl[7] && !mem_wdata[0] |=> !run);

  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mem_req && mem_we && mem_ack) || $past(reg_we && reg_addr == 2'd0));
endmodule

bind smb_desc_ring smb_desc_ring_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .eng_valid(eng_valid), .eng_ready(eng_ready),
  .eng_ctrl(eng_ctrl), .eng_dptr(eng_dptr), .tail(tail), .last(last), .run(run),
  .irq(irq), .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/tb_smb_desc_ring.sv
`timescale 1ns/1ps
module tb_smb_desc_ring;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic reg_we = 0; logic [1:0] reg_addr = 0; logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, mem_req, mem_we, mem_ack = 0; logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0;
  logic eng_valid, eng_ready = 0, eng_done = 0;
  logic [7:0] eng_tgt, eng_wlen, eng_rlen, eng_ctrl;
  logic [7:0] eng_status = 0, eng_retry = 0, eng_rxcnt = 0, eng_txcnt = 0;
  logic [63:0] eng_dptr;

  smb_desc_ring dut (.*);

  typedef struct packed { logic [7:0] tgt, wl, rl, ctl; logic [63:0] dp; } exp_t;
  exp_t q[$];
  logic [31:0] mem [0:63];
  int total = 0, bad = 0, acc = 0, cur_tail = 0, lastv = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] resp(input logic [7:0] tgt, wl, rl);
    return (tgt == 8'hEE) ? {wl, rl, 8'h03, 8'h08} : {wl, rl, 8'h00, 8'h01};
  endfunction

  task automatic mk(input int i, input logic [7:0] tgt, wl, rl, ctl,
                    input logic [63:0] dp, input bit push);
    mem[i*4]   = {ctl, rl, wl, tgt};
    mem[i*4+1] = 32'hDEADBEEF;
    mem[i*4+2] = dp[31:0];
    mem[i*4+3] = dp[63:32];
    if (push) q.push_back('{tgt, wl, rl, ctl, dp});
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_tail(input int target);
    logic [31:0] s;
    for (int n = 0; n < 3000; n++) begin
      rd(2'd1, s);
      if (int'(s[23:16]) != cur_tail) begin
        chk(int'(s[23:16]) == ((cur_tail == lastv) ? 0 : cur_tail + 1), "R6", "tail step",
            s[23:16], (cur_tail == lastv) ? 0 : cur_tail + 1);
        cur_tail = int'(s[23:16]);
      end
      if (cur_tail == target && !s[0]) return;
    end
    chk(0, "R6", "tail never reached target", cur_tail, target);
  endtask

  // memory model with changing wait states
  initial begin
    int dly = 0, seed = 0;
    forever begin
      @(negedge clk); mem_ack = 0;
      if (mem_req) begin
        if (dly == 0) begin
          mem_ack = 1; acc++;
          if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
          else mem_rdata = mem[mem_addr[7:2]];
          dly = seed % 3; seed++;
        end else dly--;
      end
    end
  end

  // engine model and scoreboard monitor
  initial begin
    int ph = 0, dly = 1, seed = 0;
    logic [31:0] r;
    exp_t e;
    forever begin
      @(negedge clk); eng_ready = 0; eng_done = 0;
      if (ph == 0 && eng_valid) begin
        if (dly != 0) dly--;
        else begin
          eng_ready = 1;
          if (q.size() == 0) chk(0, "R9", "unexpected descriptor fetched", eng_tgt, 0);
          else begin
            e = q.pop_front();
            chk({eng_tgt, eng_wlen, eng_rlen, eng_ctrl} == {e.tgt, e.wl, e.rl, e.ctl}, "R4",
                "descriptor bytes", {eng_tgt, eng_wlen, eng_rlen, eng_ctrl}, {e.tgt, e.wl, e.rl, e.ctl});
            chk(eng_dptr == e.dp, "R4", "data pointer", eng_dptr, e.dp);
          end
          r = resp(eng_tgt, eng_wlen, eng_rlen);
          {eng_txcnt, eng_rxcnt, eng_retry, eng_status} = r;
          ph = 1; dly = seed % 4; seed++;
        end
      end else if (ph == 1) begin
        if (dly != 0) dly--;
        else begin eng_done = 1; ph = 0; dly = seed % 3; seed++; end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "R3", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int snap;
    for (int i = 0; i < 64; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    chk(!mem_req, "R1", "request in reset", mem_req, 0);
    rst_n = 1;
    rd(2'd0, v); chk(v == 0, "R1", "control after reset", v, 0);
    rd(2'd1, v); chk(v == 0, "R1", "status after reset", v, 0);
    rd(2'd2, v); chk(v == 0, "R1", "size after reset", v, 0);
    chk(!irq && !mem_req, "R1", "irq/req after reset", {irq, mem_req}, 0);

    wr(2'd2, 32'h1234_5607); lastv = 7;
    rd(2'd2, v); chk(v == 32'h7, "R2", "size field", v, 7);

    mk(0, 8'h50, 8'h02, 8'h00, 8'h00, 64'h0000_0001_1000_0000, 1);
    mk(1, 8'hA1, 8'h12, 8'h01, 8'h40, 64'h8765_4321_0BAD_F00D, 1);
    mk(2, 8'h36, 8'h03, 8'h02, 8'h10, 64'h0000_0000_0000_0040, 1);
    wr(2'd0, 32'h0003_0001);
    wait_tail(3);
    chk(q.size() == 0, "R4", "first batch consumed", q.size(), 0);
    chk(mem[1] == resp(8'h50, 8'h02, 8'h00), "R5", "write-back d0", mem[1], resp(8'h50, 8'h02, 8'h00));
    chk(mem[5] == resp(8'hA1, 8'h12, 8'h01), "R5", "write-back d1", mem[5], resp(8'hA1, 8'h12, 8'h01));
    chk(mem[9] == resp(8'h36, 8'h03, 8'h02), "R5", "write-back d2", mem[9], resp(8'h36, 8'h03, 8'h02));
    rd(2'd1, v); chk(v == 32'h0003_0020, "R7", "done flag set", v, 32'h0003_0020);
    chk(irq, "R7", "irq on done", irq, 1);
    rd(2'd0, v); chk(v == 32'h0003_0001, "R2", "control readback", v, 32'h0003_0001);

    wr(2'd1, 32'h0);
    rd(2'd1, v); chk(v[5], "R10", "write 0 keeps flag", v, 32'h20);
    wr(2'd1, 32'hFFFF_FFDF);
    rd(2'd1, v); chk(v == 32'h0003_0020, "R10", "tail/busy read-only", v, 32'h0003_0020);
    wr(2'd1, 32'h20);
    rd(2'd1, v); chk(v == 32'h0003_0000, "R10", "done cleared", v, 32'h0003_0000);
    chk(!irq, "R10", "irq after clear", irq, 0);

    snap = acc;
    repeat (20) @(negedge clk);
    chk(acc == snap, "R3", "idle when tail==head", acc - snap, 0);
    mk(3, 8'h11, 8'h01, 8'h01, 8'h00, 64'h1, 0);
    wr(2'd0, 32'h0005_0000);
    repeat (20) @(negedge clk);
    chk(acc == snap, "R3", "idle when run=0", acc - snap, 0);
    rd(2'd1, v); chk(v[23:16] == 3, "R3", "tail held with run=0", v[23:16], 3);

    mk(3, 8'h60, 8'h04, 8'h00, 8'h00, 64'h3333_0000_0000_0003, 1);
    mk(4, 8'h61, 8'h05, 8'h01, 8'h00, 64'h4, 1);
    mk(5, 8'h62, 8'h06, 8'h02, 8'h40, 64'h5, 1);
    mk(6, 8'h63, 8'h07, 8'h03, 8'h00, 64'h6, 1);
    mk(7, 8'h64, 8'h08, 8'h04, 8'h00, 64'hFFFF_FFFF_0000_0007, 1);
    mk(0, 8'h65, 8'h09, 8'h05, 8'h00, 64'h8, 1);
    mk(1, 8'h66, 8'h0A, 8'h06, 8'h00, 64'h9, 1);
    wr(2'd0, 32'h0002_0001);
    wait_tail(2);
    chk(cur_tail == 2 && q.size() == 0, "R6", "wrapped ring consumed", {cur_tail, q.size()}, 2);
    chk(mem[29] == resp(8'h64, 8'h08, 8'h04), "R5", "write-back d7", mem[29], resp(8'h64, 8'h08, 8'h04));
    chk(mem[1] == resp(8'h65, 8'h09, 8'h05), "R5", "write-back after wrap", mem[1], resp(8'h65, 8'h09, 8'h05));
    wr(2'd1, 32'h30);

    mk(2, 8'hEE, 8'h01, 8'h00, 8'h00, 64'hA, 1);
    mk(3, 8'h44, 8'h02, 8'h00, 8'h00, 64'hB, 1);
    wr(2'd0, 32'h0004_0001);
    wait_tail(4);
    rd(2'd1, v); chk(v == 32'h0004_0010, "R8", "error flag set", v, 32'h0004_0010);
    chk(!irq, "R8", "error masked", irq, 0);
    chk(mem[9] == resp(8'hEE, 8'h01, 8'h00), "R5", "failed write-back", mem[9], resp(8'hEE, 8'h01, 8'h00));
    chk(q.size() == 0, "R8", "no stop without bit 7", q.size(), 0);
    wr(2'd0, 32'h0004_0011);
    chk(irq, "R8", "error unmasked", irq, 1);
    wr(2'd1, 32'h10);
    chk(!irq, "R10", "error cleared", irq, 0);

    mk(4, 8'hEE, 8'h03, 8'h01, 8'h80, 64'hC, 1);
    mk(5, 8'h45, 8'h01, 8'h00, 8'h00, 64'hD, 0);
    mk(6, 8'h46, 8'h01, 8'h00, 8'h00, 64'hE, 0);
    wr(2'd0, 32'h0007_0011);
    wait_tail(5);
    snap = acc;
    repeat (30) @(negedge clk);
    chk(acc == snap, "R9", "no fetch after stop", acc - snap, 0);
    rd(2'd0, v); chk(v == 32'h0007_0010, "R9", "run cleared", v, 32'h0007_0010);
    rd(2'd1, v); chk(v == 32'h0005_0010, "R9", "tail stopped", v, 32'h0005_0010);
    chk(irq && q.size() == 0, "R9", "irq and queue", {irq, q.size()}, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule